// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block walks a linear framebuffer in memory and turns it into a stream of 8-bit red, green and blue pixel values for a display whose line and frame timing are generated elsewhere. Each visible pixel lives in its own 32-bit memory word. Rows sit a fixed power-of-two stride of words apart, which is wider than the visible line, so the words past the last visible column of each row are never read. The default is 640 visible columns, 480 rows and a 1024-word stride.

Software programs two registers. Register index 0 holds the frame base address, of which only the upper bits are kept. Register index 1 holds an enable bit and a bit that turns the image upside down and mirrors it. The external timing source pulses `frameStart` at the top of each frame and pulses `pixEn` once for every visible pixel. The block prefetches one word ahead through a valid/ready request port and receives the data on a response port. It presents the unpacked colour one cycle after each `pixEn`. After the last visible pixel it pulses `frameDone`. A pixel whose word has not arrived by its `pixEn` is shown black and recorded in a sticky underrun flag.

Top module: `fb_scanout`

## Requirements
- R1: After reset, both registers read zero, the colour outputs are black, `reqValid` is low and `frameDone` is low.
- R2: A write to register index 0 keeps only the upper BASE_W bits (default 11) of the 32-bit value. Reading index 0 returns those bits with all lower bits zero, and those lower bits contribute nothing to any fetch address.
- R3: Register writes change the scanout only from the next `frameStart`. The frame in progress keeps the base, enable and rotation it started with, even though a read of the register already shows the new value.
- R4: Without rotation, the fetches of one frame go row by row and column by column within each row. Each byte address is base + (row × 2^STRIDE_LG + column) × 4. Only columns 0 to H_VIS−1 are fetched.
- R5: With rotation (control bit 1) set, visible pixel (r, c) is fetched from stored row V_VIS−1−r and stored column H_VIS−1−c.
- R6: On a `pixEn` whose word has arrived, the outputs show bits 23:16 as red, 15:8 as green and 7:0 as blue, registered one clock after the `pixEn` edge. Bits 31:24 are ignored.
- R7: A frame started while control bit 0 (enable) is clear issues no fetches, drives black on every `pixEn`, never pulses `frameDone` and never sets the underrun flag. A `frameStart` pulse also drives the outputs to black.
- R8: `frameDone` is high for exactly one cycle, the cycle after the edge that consumed the last visible pixel of an enabled frame. Later `pixEn` pulses give black and cause no further fetches until the next `frameStart`.
- R9: Reading register index 1 returns enable in bit 0, rotate in bit 1 and the underrun flag in bit 31. A `pixEn` in an enabled frame whose word is missing outputs black and sets the flag. Writing index 1 with bit 31 set clears it. Otherwise the flag holds. The stale word that arrives late is discarded, and the next pixel is fetched normally.
- R10: While `reqValid` is high and `reqReady` is low, `reqValid` stays high and `reqAddr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regWrIdx | input | 1 | Write index: 0 base, 1 control |
| regWrData | input | 32 | Write data |
| regRdIdx | input | 1 | Read index: 0 base, 1 control |
| regRdData | output | 32 | Read data, combinational from the index |
| frameStart | input | 1 | Top-of-frame pulse |
| pixEn | input | 1 | One pulse per visible pixel |
| reqValid | output | 1 | Fetch request valid |
| reqReady | input | 1 | Memory accepts the request |
| reqAddr | output | 32 | Byte address of the word to fetch |
| rspValid | input | 1 | Returned word valid |
| rspData | input | 32 | Returned pixel word |
| pixRed | output | 8 | Red level |
| pixGreen | output | 8 | Green level |
| pixBlue | output | 8 | Blue level |
| frameDone | output | 1 | One-cycle pulse after the last visible pixel |

## Verification
The colour outputs and `frameDone` are registered on the `pixEn` edge. The bench drives `pixEn` for one cycle from a falling edge and samples on the next falling edge. A request shows on `reqValid` one cycle after the buffer empties, is accepted on the following edge, and its word is captured one edge after that. For this reason the bench spaces pixels five cycles apart, so that every normal pixel has its word buffered. The underrun case holds `reqReady` low, so the word is known to be missing. Register reads are combinational and are sampled shortly after the index settles. The effect of a register write is checked only after the next `frameStart`.

// File: rtl/fb_scanout_pkg.sv
package fb_scanout_pkg;
  // strobes from sequencing control to the address/pixel datapath
  typedef struct packed {
    logic issue;    // latch a new fetch address
    logic capture;  // store the returned word
    logic show;     // present the stored word on the colour outputs
    logic blank;    // drive the colour outputs black
  } scanStrobe_t;
endpackage

// File: rtl/fb_scan_ctrl.sv
module fb_scan_ctrl
  import fb_scanout_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int V_VIS  = 480,
  parameter int DW     = 32,
  parameter int BASE_W = 11,
  localparam int COL_W = $clog2(H_VIS),
  localparam int ROW_W = $clog2(V_VIS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regWrIdx,
  input  logic [DW-1:0]     regWrData,
  input  logic              regRdIdx,
  output logic [DW-1:0]     regRdData,
  input  logic              frameStart,
  input  logic              pixEn,
  output logic              reqValid,
  input  logic              reqReady,
  input  logic              rspValid,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic              rotSh,
  output logic [BASE_W-1:0] baseSh,
  output scanStrobe_t       stb,
  output logic              frameDone,
  output logic              underrun
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_VIS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_VIS - 1);

  logic [BASE_W-1:0] baseReg;
  logic enReg, rotReg, active, pending, stale, bufValid;
  logic [ROW_W-1:0] tagRow;
  logic [COL_W-1:0] tagCol;
  logic step, lastPix, tagHit, clrUnd, unusedWrBits;

  assign unusedWrBits = ^regWrData[DW-BASE_W-1:2];
  assign lastPix = (row == ROW_LAST) && (col == COL_LAST);
  assign step    = pixEn && active && !frameStart;
  assign tagHit  = (tagRow == row) && (tagCol == col) && !stale;
  assign clrUnd  = regWrEn && regWrIdx && regWrData[DW-1];

  assign stb.issue   = active && !reqValid && !pending && !bufValid && !frameStart;
  assign stb.capture = rspValid && pending && tagHit && !step && !frameStart;
  assign stb.show    = step && bufValid;
  assign stb.blank   = frameStart || (pixEn && !stb.show);

  always_comb begin
    if (regRdIdx) regRdData = {underrun, (DW-3)'(0), rotReg, enReg};
    else          regRdData = {baseReg, (DW-BASE_W)'(0)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0; enReg <= 1'b0; rotReg <= 1'b0; underrun <= 1'b0;
      baseSh <= '0; rotSh <= 1'b0; active <= 1'b0; bufValid <= 1'b0;
      row <= '0; col <= '0; frameDone <= 1'b0;
      reqValid <= 1'b0; pending <= 1'b0; stale <= 1'b0;
      tagRow <= '0; tagCol <= '0;
    end else begin
      // software registers
      if (regWrEn && !regWrIdx) baseReg <= regWrData[DW-1 -: BASE_W];
      if (regWrEn && regWrIdx) begin
        enReg  <= regWrData[0];
        rotReg <= regWrData[1];
      end
      if (step && !bufValid) underrun <= 1'b1;
      else if (clrUnd)       underrun <= 1'b0;

      // pixel sequencing
      frameDone <= step && lastPix;
      if (frameStart) begin
        baseSh   <= baseReg;
        rotSh    <= rotReg;
        active   <= enReg;
        row      <= '0;
        col      <= '0;
        bufValid <= 1'b0;
      end else if (step) begin
        bufValid <= 1'b0;
        if (lastPix) active <= 1'b0;
        if (col == COL_LAST) begin
          col <= '0;
          row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end else if (stb.capture) begin
        bufValid <= 1'b1;
      end

      // single-slot fetch handshake
      if (stb.issue) begin
        reqValid <= 1'b1;
        tagRow   <= row;
        tagCol   <= col;
      end else if (reqValid && reqReady) begin
        reqValid <= 1'b0;
        pending  <= 1'b1;
      end
      if (rspValid && pending) begin
        pending <= 1'b0;
        stale   <= 1'b0;
      end else if (frameStart && (reqValid || pending)) begin
        stale <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fb_scan_dpath.sv
module fb_scan_dpath
  import fb_scanout_pkg::*;
#(
  parameter int H_VIS     = 640,
  parameter int V_VIS     = 480,
  parameter int STRIDE_LG = 10,
  parameter int DW        = 32,
  parameter int BASE_W    = 11,
  localparam int COL_W    = $clog2(H_VIS),
  localparam int ROW_W    = $clog2(V_VIS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobe_t       stb,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic              rot,
  input  logic [BASE_W-1:0] base,
  input  logic [DW-1:0]     rspData,
  output logic [DW-1:0]     reqAddr,
  output logic [7:0]        pixRed,
  output logic [7:0]        pixGreen,
  output logic [7:0]        pixBlue
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_VIS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_VIS - 1);

  logic [ROW_W-1:0] srcRow;
  logic [COL_W-1:0] srcCol;
  logic [DW-1:0]    offset;
  logic [23:0]      dataBuf;
  logic             unusedPad;

  assign unusedPad = ^rspData[DW-1:24];
  assign srcRow = rot ? (ROW_LAST - row) : row;
  assign srcCol = rot ? (COL_LAST - col) : col;
  assign offset = (DW'(srcRow) << (STRIDE_LG + 2)) + (DW'(srcCol) << 2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr <= '0;
      dataBuf <= '0;
      {pixRed, pixGreen, pixBlue} <= '0;
    end else begin
      if (stb.issue)   reqAddr <= {base, (DW-BASE_W)'(0)} + offset;
      if (stb.capture) dataBuf <= rspData[23:0];
      if (stb.blank)     {pixRed, pixGreen, pixBlue} <= '0;
      else if (stb.show) {pixRed, pixGreen, pixBlue} <= dataBuf;
    end
  end
endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
  import fb_scanout_pkg::*;
#(
  parameter int H_VIS     = 640,
  parameter int V_VIS     = 480,
  parameter int STRIDE_LG = 10,
  parameter int BASE_W    = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regWrIdx,
  input  logic [31:0] regWrData,
  input  logic        regRdIdx,
  output logic [31:0] regRdData,
  input  logic        frameStart,
  input  logic        pixEn,
  output logic        reqValid,
  input  logic        reqReady,
  output logic [31:0] reqAddr,
  input  logic        rspValid,
  input  logic [31:0] rspData,
  output logic [7:0]  pixRed,
  output logic [7:0]  pixGreen,
  output logic [7:0]  pixBlue,
  output logic        frameDone
);
  localparam int COL_W = $clog2(H_VIS);
  localparam int ROW_W = $clog2(V_VIS);

  scanStrobe_t       stb;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic              rotSh;
  logic [BASE_W-1:0] baseSh;
  logic              underrunSticky;

  fb_scan_ctrl #(.H_VIS(H_VIS), .V_VIS(V_VIS), .DW(32), .BASE_W(BASE_W)) u_ctrl (
    .clk, .rstN, .regWrEn, .regWrIdx, .regWrData, .regRdIdx, .regRdData,
    .frameStart, .pixEn, .reqValid, .reqReady, .rspValid,
    .row, .col, .rotSh, .baseSh, .stb, .frameDone, .underrun(underrunSticky)
  );

  fb_scan_dpath #(.H_VIS(H_VIS), .V_VIS(V_VIS), .STRIDE_LG(STRIDE_LG), .DW(32),
                  .BASE_W(BASE_W)) u_dpath (
    .clk, .rstN, .stb, .row, .col, .rot(rotSh), .base(baseSh), .rspData,
    .reqAddr, .pixRed, .pixGreen, .pixBlue
  );
endmodule

// File: rtl/fb_scanout_chk.sv
module fb_scanout_chk #(
  parameter int H_VIS     = 640,
  parameter int STRIDE_LG = 10
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqAddr,
  input logic        frameStart,
  input logic        frameDone,
  input logic [7:0]  pixRed,
  input logic [7:0]  pixGreen,
  input logic [7:0]  pixBlue,
  input logic        wrClr,
  input logic        underrunSticky
);
  // R10: a stalled request holds valid and address
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr));

  // R4: the column field of a fetch never reaches the invisible words
  a_r4_col_visible: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (32'(reqAddr[2 +: STRIDE_LG]) < H_VIS));

  // R8: frame-done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R7: a frame start leaves the outputs black
  a_r7_start_black: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (pixRed == 8'd0) && (pixGreen == 8'd0) && (pixBlue == 8'd0));

  // R9: the underrun flag holds until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    underrunSticky && !wrClr |=> underrunSticky);
endmodule

bind fb_scanout fb_scanout_chk #(.H_VIS(H_VIS), .STRIDE_LG(STRIDE_LG)) i_chk (
  .clk, .rstN, .reqValid, .reqReady, .reqAddr, .frameStart, .frameDone,
  .pixRed, .pixGreen, .pixBlue,
  .wrClr(regWrEn && regWrIdx && regWrData[31]),
  .underrunSticky
);

// File: tb/test_fb_scanout.sv
`timescale 1ns/1ps
module test_fb_scanout;
  localparam int H = 8;
  localparam int V = 4;
  localparam int SLG = 4;
  localparam logic [31:0] KEEP = 32'hFFE0_0000;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0, regWrIdx = 1'b0, regRdIdx = 1'b0;
  logic [31:0] regWrData = '0, regRdData;
  logic frameStart = 1'b0, pixEn = 1'b0;
  logic reqValid, reqReady, rspValid = 1'b0, frameDone;
  logic [31:0] reqAddr, rspData = '0;
  logic [7:0] pixRed, pixGreen, pixBlue;
  logic memStall = 1'b0;
  int checks = 0, errors = 0, acceptCnt = 0;
  logic [31:0] acceptLog [64];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign reqReady = !memStall;

  fb_scanout #(.H_VIS(H), .V_VIS(V), .STRIDE_LG(SLG), .BASE_W(11)) i_fb_scanout (
    .clk, .rstN, .regWrEn, .regWrIdx, .regWrData, .regRdIdx, .regRdData,
    .frameStart, .pixEn, .reqValid, .reqReady, .reqAddr, .rspValid, .rspData,
    .pixRed, .pixGreen, .pixBlue, .frameDone
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {8'hEE, a[23:0] ^ 24'h3C5A96};
  endfunction

  function automatic logic [31:0] expAddr(input logic [31:0] b, input bit rot,
                                          input int r, input int c);
    int sr = rot ? (V - 1 - r) : r;
    int sc = rot ? (H - 1 - c) : c;
    return (b & KEEP) + 32'((sr * (1 << SLG) + sc) * 4);
  endfunction

  // memory model: one-cycle response after acceptance
  initial begin
    logic due = 1'b0;
    logic [31:0] dueAddr = '0;
    forever begin
      @(negedge clk); #1;
      rspValid = 1'b0;
      if (due) begin rspValid = 1'b1; rspData = memWord(dueAddr); due = 1'b0; end
      if (reqValid && reqReady) begin
        due = 1'b1; dueAddr = reqAddr;
        if (acceptCnt < 64) acceptLog[acceptCnt] = reqAddr;
        acceptCnt++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input bit idx, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrIdx = idx; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input bit idx, output logic [31:0] d);
    regRdIdx = idx; #0.5; d = regRdData;
  endtask

  task automatic startFrame();
    @(negedge clk); frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
  endtask

  task automatic doPix(output logic [23:0] rgb);
    repeat (4) @(negedge clk);
    pixEn = 1'b1;
    @(negedge clk); pixEn = 1'b0;
    rgb = {pixRed, pixGreen, pixBlue};
  endtask

  // one enabled frame; optional mid-frame register write after pixel 10
  task automatic runFrame(input string req, input logic [31:0] b, input bit rot,
                          input bit midWrite);
    logic [23:0] rgb;
    int bad = 0;
    acceptCnt = 0;
    startFrame();
    for (int r = 0; r < V; r++) begin
      for (int c = 0; c < H; c++) begin
        doPix(rgb);
        if (rgb !== memWord(expAddr(b, rot, r, c))[23:0]) begin
          if (bad == 0) check({req, " R6 pixel"}, 32'(rgb), 32'(memWord(expAddr(b, rot, r, c))[23:0]));
          bad++;
        end
        if (r == V - 1 && c == H - 1) check({req, " R8 done pulse"}, 32'(frameDone), 32'd1);
        else if (frameDone) check({req, " R8 early done"}, 32'(frameDone), 32'd0);
        if (midWrite && r == 1 && c == 2) begin
          regWrite(1'b0, 32'h7654_3210);
          regWrite(1'b1, 32'h0000_0003);
        end
      end
    end
    if (bad == 0) check({req, " R6 all pixels"}, 32'd0, 32'd0);
    @(negedge clk);
    check({req, " R8 done one cycle"}, 32'(frameDone), 32'd0);
    check({req, " R4 fetch count"}, 32'(acceptCnt), 32'(H * V));
    for (int i = 0; i < H * V; i++) begin
      if (acceptLog[i] !== expAddr(b, rot, i / H, i % H)) begin
        check({req, " R4 fetch order"}, acceptLog[i], expAddr(b, rot, i / H, i % H));
        break;
      end
    end
    doPix(rgb);
    check({req, " R8 black after last"}, 32'(rgb), 32'd0);
    repeat (4) @(negedge clk);
    check({req, " R8 no fetch after done"}, 32'(acceptCnt), 32'(H * V));
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRead(1'b0, d); check("R1 base reg", d, 32'd0);
    regRead(1'b1, d); check("R1 ctrl reg", d, 32'd0);
    check("R1 colour", {8'd0, pixRed, pixGreen, pixBlue}, 32'd0);
    check("R1 reqValid/frameDone", {30'd0, reqValid, frameDone}, 32'd0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    regWrite(1'b0, 32'hFFFF_FFFF);
    regRead(1'b0, d); check("R2 base keeps top bits", d, 32'hFFE0_0000);
    regWrite(1'b1, 32'h0000_0003);
    regRead(1'b1, d); check("R9 ctrl read format", d, 32'h0000_0003);
  endtask

  task automatic testScan();
    logic [31:0] d;
    regWrite(1'b0, 32'h1234_5678);
    regWrite(1'b1, 32'h0000_0001);
    // R3: writes inside the frame must not disturb it
    runFrame("R4 plain frame, R3 deferred write", 32'h1234_5678, 1'b0, 1'b1);
    regRead(1'b1, d); check("R3 ctrl shows new value, R9 no underrun", d, 32'h0000_0003);
    regRead(1'b0, d); check("R2 base low bits dropped", d, 32'h7640_0000);
  endtask

  task automatic testRotate();
    runFrame("R5 rotated frame, R3 applied", 32'h7654_3210, 1'b1, 1'b0);
  endtask

  task automatic testOff();
    logic [23:0] rgb;
    logic [31:0] d;
    bit sawDone = 1'b0;
    regWrite(1'b1, 32'h0000_0000);
    acceptCnt = 0;
    startFrame();
    for (int i = 0; i < 3; i++) begin
      doPix(rgb);
      check("R7 black while off", 32'(rgb), 32'd0);
      if (frameDone) sawDone = 1'b1;
    end
    check("R7 no fetch while off", 32'(acceptCnt), 32'd0);
    check("R7 no done while off", 32'(sawDone), 32'd0);
    regRead(1'b1, d); check("R7 no underrun while off", d, 32'd0);
  endtask

  task automatic testUnderrun();
    logic [23:0] rgb;
    logic [31:0] d;
    logic [31:0] b = 32'hA000_0000;
    regWrite(1'b0, b);
    regWrite(1'b1, 32'h0000_0001);
    memStall = 1'b1;
    startFrame();
    repeat (3) @(negedge clk);
    check("R10 stalled request valid", 32'(reqValid), 32'd1);
    check("R10 stalled address", reqAddr, expAddr(b, 1'b0, 0, 0));
    repeat (3) @(negedge clk);
    check("R10 address held", reqAddr, expAddr(b, 1'b0, 0, 0));
    doPix(rgb);
    check("R9 underrun pixel black", 32'(rgb), 32'd0);
    regRead(1'b1, d); check("R9 underrun flag set", d, 32'h8000_0001);
    memStall = 1'b0;
    repeat (10) @(negedge clk);
    regRead(1'b1, d); check("R9 flag sticky", d, 32'h8000_0001);
    doPix(rgb);
    check("R9 recovery next pixel", 32'(rgb), 32'(memWord(expAddr(b, 1'b0, 0, 1))[23:0]));
    regWrite(1'b1, 32'h8000_0001);
    regRead(1'b1, d); check("R9 flag cleared by write", d, 32'h0000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testRegs();
    testScan();
    testRotate();
    testOff();
    testUnderrun();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule